// File: doc/BRIEF.md
# Converter Result Serial Port

This block places the result of a successive-approximation conversion on one serial data line, most significant bit first. It offers two ways to read. While a conversion runs, every bit the approximation logic decides shows up on the line right away, paced by the conversion clock. After the conversion ends, the finished word is stored. A host can then shift it out on its own serial clock, which has no fixed phase relation to the conversion clock.

An active-low chip select gates the line. While it is high, the output enable is low and the line can be left undriven. Each time it goes low, a readout starts again at the most significant bit. At the end of a conversion the finished word is captured in the conversion-clock domain. A toggle request, synchronised by a flop chain, then moves it into the serial-clock domain. The stored copy there changes only while chip select is high, so a readout in progress always sees one consistent word.

Top module: `adc_serial_port`

## Requirements
- R1: While `cs_ni` is 1, `sdo_oe_o` is 0 and `sdo_o` is 0.
- R2: While `cs_ni` is 0, `sdo_oe_o` is 1.
- R3: Live mode begins at a `cclk_i` rising edge that samples `conv_busy_i` as 1. From that edge until the edge that samples it as 0, and with `cs_ni` at 0, `sdo_o` shows the live bit. The live bit is 0 from the first busy edge. At each later edge with `dec_stb_i` at 1 it takes `dec_bit_i`, and it holds that value until the next strobe.
- R4: Two consecutive `cclk_i` rising edges that sample `conv_busy_i` as 1 and then 0 end a conversion. The second of these edges captures `result_i`. The captured word becomes the stored word after SYNC_N+1 `sclk_i` rising edges with `cs_ni` at 1. Input changes after the capture edge do not alter it.
- R5: Outside live mode, a stored readout puts bit DATA_W-1 on `sdo_o` as soon as `cs_ni` falls. Each `sclk_i` falling edge with `cs_ni` at 0 moves the line to the next lower bit, so data is stable at the rising edges.
- R6: After DATA_W falling edges of `sclk_i`, `sdo_o` stays 0 until `cs_ni` rises.
- R7: Every falling edge of `cs_ni` restarts the readout at bit DATA_W-1. A word can be read again, and a partial read followed by a new one starts over.
- R8: While `cs_ni` stays 0, the stored word does not change, even if a conversion completes. A conversion that completes in that time is read on the next readout, once `cs_ni` has risen.
- R9: After reset, `sdo_o` is 0 and the stored word is all zeros, so a readout before any conversion yields zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cclk_i | input | 1 | Conversion clock |
| sclk_i | input | 1 | Serial read clock, asynchronous to cclk_i |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| conv_busy_i | input | 1 | High while a conversion is in progress |
| dec_stb_i | input | 1 | One-cycle strobe marking a newly decided bit |
| dec_bit_i | input | 1 | Value of the decided bit |
| result_i | input | DATA_W | Completed result word, valid when busy drops |
| sdo_o | output | 1 | Serial data |
| sdo_oe_o | output | 1 | Output enable for the three-state data line |

## Verification
A live bit is due one `cclk_i` rising edge after its strobe. The bench drives strobes at falling edges and compares the line at the next falling edge, both right after the strobe and one idle cycle later. In stored mode the line moves at `sclk_i` falling edges. The bench keeps its own count of those edges and compares at 1 ns after each rising edge, which is where a reader samples. Before each readout the bench waits five serial rising edges with chip select high, which covers the SYNC_N+1 edges the transfer needs. During and just after a conversion, serial-side samples are skipped, because the line then belongs to live mode.

// File: rtl/adc_sp_pkg.sv
`timescale 1ns/100ps
package adc_sp_pkg;
  localparam int unsigned DEF_DATA_W = 14;
  localparam int unsigned DEF_SYNC_N = 2;

  typedef enum logic [1:0] {
    SRC_OFF  = 2'd0,
    SRC_LIVE = 2'd1,
    SRC_WORD = 2'd2,
    SRC_TAIL = 2'd3
  } sdo_src_e;
endpackage

// File: rtl/adc_sp_live.sv
`timescale 1ns/100ps
module adc_sp_live (
  input  logic cclk_i,
  input  logic rst_ni,
  input  logic conv_busy_i,
  input  logic dec_stb_i,
  input  logic dec_bit_i,
  output logic live_mode_o,
  output logic live_bit_o,
  output logic conv_end_o
);
  logic conv_q;
  logic bit_q;

  always_ff @(posedge cclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      conv_q <= 1'b0;
      bit_q  <= 1'b0;
    end else begin
      conv_q <= conv_busy_i;
      if (conv_busy_i && !conv_q) begin
        bit_q <= 1'b0;          // fresh conversion: nothing decided yet
      end else if (conv_q && dec_stb_i) begin
        bit_q <= dec_bit_i;
      end
    end
  end

  assign live_mode_o = conv_q;
  assign live_bit_o  = bit_q;
  assign conv_end_o  = conv_q & ~conv_busy_i;
endmodule

// File: rtl/adc_sp_capture.sv
`timescale 1ns/100ps
module adc_sp_capture #(
  parameter int unsigned DATA_W = adc_sp_pkg::DEF_DATA_W,
  parameter int unsigned SYNC_N = adc_sp_pkg::DEF_SYNC_N
) (
  input  logic              cclk_i,
  input  logic              sclk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              conv_end_i,
  input  logic [DATA_W-1:0] result_i,
  output logic [DATA_W-1:0] xfer_word_o,
  output logic              xfer_req_o,
  output logic [DATA_W-1:0] rd_word_o
);
  logic [DATA_W-1:0] xfer_q;
  logic              req_q;
  logic [SYNC_N-1:0] sync_q;
  logic              seen_q;
  logic [DATA_W-1:0] rd_q;
  logic              req_arrived;

  // conversion-clock side: hold word, flip request
  always_ff @(posedge cclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      xfer_q <= '0;
      req_q  <= 1'b0;
    end else if (conv_end_i) begin
      xfer_q <= result_i;
      req_q  <= ~req_q;
    end
  end

  // serial-clock side: synchroniser chain
  always_ff @(posedge sclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q[0] <= req_q;
      for (int i = 1; i < SYNC_N; i++) begin
        sync_q[i] <= sync_q[i-1];
      end
    end
  end

  assign req_arrived = sync_q[SYNC_N-1] ^ seen_q;

  // load only while deselected so a readout never sees a torn word
  always_ff @(posedge sclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q <= 1'b0;
      rd_q   <= '0;
    end else if (cs_ni && req_arrived) begin
      seen_q <= sync_q[SYNC_N-1];
      rd_q   <= xfer_q;
    end
  end

  assign xfer_word_o = xfer_q;
  assign xfer_req_o  = req_q;
  assign rd_word_o   = rd_q;
endmodule

// File: rtl/adc_sp_shift.sv
`timescale 1ns/100ps
module adc_sp_shift #(
  parameter int unsigned DATA_W = adc_sp_pkg::DEF_DATA_W,
  localparam int unsigned CNT_W = $clog2(DATA_W + 1)
) (
  input  logic              sclk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic [DATA_W-1:0] rd_word_i,
  output logic [CNT_W-1:0]  bit_cnt_o,
  output logic              word_bit_o,
  output logic              tail_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W);

  logic              clr;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] shifted;

  assign clr = cs_ni | ~rst_ni;

  // advance on falling edge; deselect returns to the MSB
  always_ff @(negedge sclk_i or posedge clr) begin
    if (clr) begin
      cnt_q <= '0;
    end else if (cnt_q != LAST) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign shifted    = rd_word_i << cnt_q;
  assign word_bit_o = shifted[DATA_W-1];
  assign tail_o     = (cnt_q == LAST);
  assign bit_cnt_o  = cnt_q;
endmodule

// File: rtl/adc_serial_port.sv
`timescale 1ns/100ps
module adc_serial_port #(
  parameter int unsigned DATA_W = adc_sp_pkg::DEF_DATA_W,
  parameter int unsigned SYNC_N = adc_sp_pkg::DEF_SYNC_N
) (
  input  logic              cclk_i,
  input  logic              sclk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              conv_busy_i,
  input  logic              dec_stb_i,
  input  logic              dec_bit_i,
  input  logic [DATA_W-1:0] result_i,
  output logic              sdo_o,
  output logic              sdo_oe_o
);
  import adc_sp_pkg::*;

  localparam int unsigned CNT_W = $clog2(DATA_W + 1);

  logic              live_mode;
  logic              live_bit;
  logic              conv_end;
  logic [DATA_W-1:0] xfer_word;
  logic              xfer_req;
  logic [DATA_W-1:0] rd_word;
  logic [CNT_W-1:0]  bit_cnt;
  logic              word_bit;
  logic              tail;
  sdo_src_e          src;

  adc_sp_live u_live (
    .cclk_i      (cclk_i),
    .rst_ni      (rst_ni),
    .conv_busy_i (conv_busy_i),
    .dec_stb_i   (dec_stb_i),
    .dec_bit_i   (dec_bit_i),
    .live_mode_o (live_mode),
    .live_bit_o  (live_bit),
    .conv_end_o  (conv_end)
  );

  adc_sp_capture #(.DATA_W(DATA_W), .SYNC_N(SYNC_N)) u_capture (
    .cclk_i      (cclk_i),
    .sclk_i      (sclk_i),
    .rst_ni      (rst_ni),
    .cs_ni       (cs_ni),
    .conv_end_i  (conv_end),
    .result_i    (result_i),
    .xfer_word_o (xfer_word),
    .xfer_req_o  (xfer_req),
    .rd_word_o   (rd_word)
  );

  adc_sp_shift #(.DATA_W(DATA_W)) u_shift (
    .sclk_i     (sclk_i),
    .rst_ni     (rst_ni),
    .cs_ni      (cs_ni),
    .rd_word_i  (rd_word),
    .bit_cnt_o  (bit_cnt),
    .word_bit_o (word_bit),
    .tail_o     (tail)
  );

  always_comb begin
    if (cs_ni)          src = SRC_OFF;
    else if (live_mode) src = SRC_LIVE;
    else if (tail)      src = SRC_TAIL;
    else                src = SRC_WORD;
  end

  always_comb begin
    unique case (src)
      SRC_LIVE: sdo_o = live_bit;
      SRC_WORD: sdo_o = word_bit;
      default:  sdo_o = 1'b0;
    endcase
  end

  assign sdo_oe_o = ~cs_ni;
endmodule

// File: rtl/adc_sp_checker.sv
`timescale 1ns/100ps
module adc_sp_checker #(
  parameter int unsigned DATA_W = adc_sp_pkg::DEF_DATA_W,
  localparam int unsigned CNT_W = $clog2(DATA_W + 1)
) (
  input logic              cclk_i,
  input logic              sclk_i,
  input logic              rst_ni,
  input logic              cs_ni,
  input logic              conv_busy_i,
  input logic              dec_stb_i,
  input logic [DATA_W-1:0] result_i,
  input logic              sdo_o,
  input logic              sdo_oe_o,
  input logic              live_mode,
  input logic              live_bit,
  input logic [DATA_W-1:0] xfer_word,
  input logic              xfer_req,
  input logic [DATA_W-1:0] rd_word,
  input logic [CNT_W-1:0]  bit_cnt
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W);

  assert_hiz_R1: assert property (@(posedge cclk_i) disable iff (!rst_ni)
    cs_ni |-> (!sdo_oe_o && !sdo_o))
    else $error("R1 line driven while deselected");

  assert_live_out_R3: assert property (@(posedge cclk_i) disable iff (!rst_ni)
    (live_mode && !cs_ni) |-> (sdo_o == live_bit))
    else $error("R3 live bit not on line");

  assert_live_hold_R3: assert property (@(posedge cclk_i) disable iff (!rst_ni)
    ($past(live_mode) && !$past(dec_stb_i)) |-> $stable(live_bit))
    else $error("R3 live bit moved without strobe");

  assert_capture_R4: assert property (@(posedge cclk_i) disable iff (!rst_ni)
    (live_mode && !conv_busy_i) |=> (xfer_word == $past(result_i)))
    else $error("R4 word not captured at end of conversion");

  assert_req_flip_R4: assert property (@(posedge cclk_i) disable iff (!rst_ni)
    (live_mode && !conv_busy_i) |=> (xfer_req != $past(xfer_req)))
    else $error("R4 request not raised");

  assert_tail_zero_R6: assert property (@(posedge sclk_i) disable iff (!rst_ni)
    (!cs_ni && !live_mode && bit_cnt == LAST) |-> !sdo_o)
    else $error("R6 line not zero after last bit");

  assert_cnt_sat_R6: assert property (@(posedge sclk_i) disable iff (!rst_ni)
    bit_cnt <= LAST)
    else $error("R6 bit counter past end");

  assert_frozen_R8: assert property (@(posedge sclk_i) disable iff (!rst_ni)
    (!cs_ni && $past(!cs_ni)) |-> $stable(rd_word))
    else $error("R8 stored word changed during readout");
endmodule

bind adc_serial_port adc_sp_checker #(.DATA_W(DATA_W)) u_chk (
  .cclk_i      (cclk_i),
  .sclk_i      (sclk_i),
  .rst_ni      (rst_ni),
  .cs_ni       (cs_ni),
  .conv_busy_i (conv_busy_i),
  .dec_stb_i   (dec_stb_i),
  .result_i    (result_i),
  .sdo_o       (sdo_o),
  .sdo_oe_o    (sdo_oe_o),
  .live_mode   (live_mode),
  .live_bit    (live_bit),
  .xfer_word   (xfer_word),
  .xfer_req    (xfer_req),
  .rd_word     (rd_word),
  .bit_cnt     (bit_cnt)
);

// File: tb/adc_serial_port_tb.sv
`timescale 1ns/100ps
module adc_serial_port_tb;
  localparam int W = 14;

  logic         cclk = 1'b0;
  logic         sclk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cs_n = 1'b1;
  logic         busy = 1'b0;
  logic         stb = 1'b0;
  logic         dbit = 1'b0;
  logic [W-1:0] result = '0;
  logic         sdo;
  logic         sdo_oe;

  int           n_chk = 0;
  int           n_err = 0;
  int           bcnt = 0;
  bit           rd_chk = 1'b0;
  bit           busy_win = 1'b0;
  logic [W-1:0] rd_exp = '0;
  string        tag = "R5";

  always #2.5  cclk = ~cclk;
  always #18.5 sclk = ~sclk;

  adc_serial_port #(.DATA_W(W), .SYNC_N(2)) u_dut (
    .cclk_i      (cclk),
    .sclk_i      (sclk),
    .rst_ni      (rst_n),
    .cs_ni       (cs_n),
    .conv_busy_i (busy),
    .dec_stb_i   (stb),
    .dec_bit_i   (dbit),
    .result_i    (result),
    .sdo_o       (sdo),
    .sdo_oe_o    (sdo_oe)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s at %0t: actual=%0b expected=%0b", req, $time, act, exp);
    end
  endtask

  // enable and deselected line compared on every conversion clock
  always @(negedge cclk) begin
    if (rst_n) begin
      chk("R2", sdo_oe, ~cs_n);
      if (cs_n) chk("R1", sdo, 1'b0);
    end
  end

  // reference bit position: falling serial edges since select
  always @(negedge sclk) if (!cs_n) bcnt++;

  // stored-mode line compared where a reader samples
  always @(posedge sclk) begin
    #1;
    if (rd_chk && !busy_win && !cs_n) begin
      if (bcnt < W) chk(tag, sdo, rd_exp[W-1-bcnt]);
      else          chk("R6", sdo, 1'b0);
    end
  end

  task automatic cs_drop(input logic [W-1:0] exp, input string t);
    @(negedge sclk);
    #2.2;
    rd_exp = exp;
    tag    = t;
    bcnt   = 0;
    cs_n   = 1'b0;
    #1;
    chk(t, sdo, exp[W-1]);   // MSB present before any serial edge
    rd_chk = 1'b1;
  endtask

  task automatic read_word(input logic [W-1:0] exp, input string t, input int n);
    cs_drop(exp, t);
    repeat (n) @(posedge sclk);
    #2.2;
    rd_chk = 1'b0;
    cs_n   = 1'b1;
  endtask

  task automatic settle();
    repeat (5) @(posedge sclk);
  endtask

  task automatic run_conv(input logic [W-1:0] word);
    @(negedge cclk);
    busy_win = 1'b1;
    busy     = 1'b1;
    @(negedge cclk);
    if (!cs_n) chk("R3", sdo, 1'b0);
    for (int i = W - 1; i >= 0; i--) begin
      stb  = 1'b1;
      dbit = word[i];
      @(negedge cclk);
      stb = 1'b0;
      if (!cs_n) chk("R3", sdo, word[i]);
      dbit = ~word[i];
      @(negedge cclk);
      if (!cs_n) chk("R3", sdo, word[i]);
    end
    result = word;
    busy   = 1'b0;
    @(negedge cclk);
    result   = ~word;            // later change must not reach the stored word (R4)
    busy_win = 1'b0;
  endtask

  initial begin
    #1000000;
    n_err++;
    $display("FAIL watchdog expired at %0t", $time);
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge cclk);
    rst_n = 1'b1;
    #1;
    chk("R9", sdo, 1'b0);
    chk("R9", sdo_oe, 1'b0);
    repeat (2) @(posedge sclk);
    read_word('0, "R9", W + 2);

    run_conv(14'h2A5B);
    settle();
    read_word(14'h2A5B, "R5", W + 2);

    read_word(14'h2A5B, "R7", 5);
    read_word(14'h2A5B, "R7", W + 1);

    // live read during conversion
    @(negedge sclk);
    #2.2;
    cs_n = 1'b0;
    run_conv(14'h1C36);
    @(posedge sclk);
    #2.2;
    cs_n = 1'b1;
    settle();
    read_word(14'h1C36, "R4", W + 2);

    // conversion completing in the middle of a readout
    cs_drop(14'h1C36, "R8");
    repeat (3) @(posedge sclk);
    run_conv(14'h0F0F);
    repeat (W) @(posedge sclk);
    #2.2;
    rd_chk = 1'b0;
    cs_n   = 1'b1;
    settle();
    read_word(14'h0F0F, "R8", W + 2);

    repeat (4) @(posedge sclk);
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule